// File: doc/BRIEF.md
# GPIO Edge Detector and Interrupt Aggregator

This block watches 128 general-purpose pins, arranged as four banks of 32, and records their level transitions as interrupt events. Each pad passes through a two-flop synchroniser. A transition is found by comparing the synchronised level with its copy from one cycle earlier. For each bank, a companion register block supplies three configuration words: direction, rising-edge enable and falling-edge enable. An enabled transition on a pin configured as an input sets a sticky bit in that bank's status word. The bit stays set until software writes a one to it, which the companion block delivers as a per-bank clear strobe plus a shared clear data word.

The interrupt outputs are deliberately uneven. Bit 0 and bit 1 of bank 0 each drive their own interrupt line. Every other status bit in all banks is ORed onto one shared line. A fixed per-bank mask, set by a parameter, marks which pins may wake a halted core. While the halted input is high, any level change on a masked pin that is configured as an input produces a one-cycle wake request. The edge enables play no part in this.

Top module: `gpio_edge_irq_top`

## Requirements
- R1: Pin p maps to bank p/32, bit p%32 of `status_o` (bit p overall). A low-to-high change on pin p sets that bit if `rise_en[p]`=1 and `pin_dir[p]`=0, where 0 means input.
- R2: A high-to-low change on pin p sets status bit p if `fall_en[p]`=1 and `pin_dir[p]`=0.
- R3: A pin with `pin_dir[p]`=1 (output) never sets its status bit and never raises a wake request, whatever its enables are.
- R4: Status bits are sticky. A cycle with `clr_we[b]`=1 clears exactly the bits of bank b where `clr_data` holds a 1, and leaves every other bit unchanged.
- R5: If a new edge and a clear of the same bit occur in the same cycle, the bit stays set.
- R6: A pad change driven before clock edge E0 shows up in `status_o` after edge E2, and in the interrupt outputs after edge E3. `irq_pin0` follows status bit 0, and `irq_pin1` follows status bit 1.
- R7: `irq_shared` is high, one cycle after the status, exactly when any status bit other than bits 0 and 1 is set.
- R8: While `halted`=1, a change in either direction on an input pin whose bit is set in the wake mask gives `wake_req` high for exactly one cycle. The change needs no edge enable. The default masks for banks 0 to 3 are 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F.
- R9: While reset is active, and right after it, all status bits, all interrupt lines and `wake_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pad_in | input | 128 | Asynchronous pad levels |
| pin_dir | input | 128 | 1 = pin is an output |
| rise_en | input | 128 | Rising-edge detect enables |
| fall_en | input | 128 | Falling-edge detect enables |
| clr_we | input | 4 | Per-bank status clear strobe |
| clr_data | input | 32 | Write-one-to-clear mask |
| halted | input | 1 | Core is halted |
| status_o | output | 128 | Sticky edge status, bank 0 in low bits |
| irq_pin0 | output | 1 | Interrupt for bank 0 bit 0 |
| irq_pin1 | output | 1 | Interrupt for bank 0 bit 1 |
| irq_shared | output | 1 | Interrupt for all other status bits |
| wake_req | output | 1 | One-cycle wake pulse |

## Verification
The bench uses the default parameters: four banks of 32 pins and the four listed wake masks. With these values it can test the dedicated lines on bank 0 and the shared line from the highest pin, 127. It can also check wake masking on pins that are inside a mask (bank 0 bit 0, bank 1 bit 8, bank 3 bit 0) and on one that is outside (bank 0 bit 2). Keeping the full 32-bit bank width lets the bench test partial clears and the race between an edge and a clear on neighbouring bits.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
    localparam int unsigned DEF_BANKS  = 4;
    localparam int unsigned DEF_BANK_W = 32;
    // bank 3 .. bank 0, bank 0 in the low word
    localparam logic [DEF_BANKS*DEF_BANK_W-1:0] DEF_WAKE_MASK =
        128'h0012007F_EC080000_002001FC_8003FE1B;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = d_async;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_sync = st_q.stable;
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
    parameter int unsigned W = 32,
    parameter logic [W-1:0] WAKE_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] dir_i,
    input  logic [W-1:0] rise_en_i,
    input  logic [W-1:0] fall_en_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] clr_data_i,
    input  logic         halted_i,
    output logic [W-1:0] status_o,
    output logic         wake_hit_o
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] status;
    } bank_t;

    bank_t        st_d, st_q;
    logic [W-1:0] set_mask;
    logic [W-1:0] clr_mask;
    logic [W-1:0] is_input;

    always_comb begin
        st_d       = st_q;
        is_input   = ~dir_i;
        set_mask   = ((lvl_i & ~st_q.prev & rise_en_i) |
                      (~lvl_i & st_q.prev & fall_en_i)) & is_input;
        clr_mask   = clr_we_i ? clr_data_i : '0;
        st_d.prev  = lvl_i;
        // a fresh edge overrides a simultaneous clear
        st_d.status = (st_q.status & ~clr_mask) | set_mask;
        wake_hit_o = halted_i & (|((lvl_i ^ st_q.prev) & is_input & WAKE_MASK));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;

    // R4: a set bit only falls when a clear covered it
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(status_o) & ~$past(clr_mask)) & ~status_o) == '0));

    // R3: newly set bits belonged to input pins
    p_input_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((status_o & ~$past(status_o)) & $past(dir_i)) == '0));

    // R5: a cleared bit without a fresh edge is low afterwards, an edged bit is high
    p_clear_vs_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(clr_mask & ~set_mask) & status_o) == '0) &&
                  (($past(set_mask) & ~status_o) == '0)));
endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg #(
    parameter int unsigned NB = 4,
    parameter int unsigned W  = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB*W-1:0] status_i,
    input  logic [NB-1:0] wake_hit_i,
    output logic          irq0_o,
    output logic          irq1_o,
    output logic          irqx_o,
    output logic          wake_o
);
    localparam int unsigned TOT = NB * W;

    typedef struct packed {
        logic irq0;
        logic irq1;
        logic irqx;
        logic wake;
    } agg_t;

    agg_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.irq0 = status_i[0];
        st_d.irq1 = status_i[1];
        st_d.irqx = |status_i[TOT-1:2];
        st_d.wake = |wake_hit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq0_o = st_q.irq0;
    assign irq1_o = st_q.irq1;
    assign irqx_o = st_q.irqx;
    assign wake_o = st_q.wake;

    // R6: dedicated lines trail their status bits by one cycle
    p_dedicated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq0_o == $past(status_i[0]) && irq1_o == $past(status_i[1])));

    // R7: shared line never high when no other status bit was set
    p_shared_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status_i[TOT-1:2]) == '0) |-> !irqx_o);

    // R8: a wake pulse always comes from a bank hit the cycle before
    p_wake_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> $past(|wake_hit_i));
endmodule

// File: rtl/gpio_edge_irq_top.sv
module gpio_edge_irq_top
    import gpio_edge_pkg::*;
#(
    parameter int unsigned NB = DEF_BANKS,
    parameter int unsigned W  = DEF_BANK_W,
    parameter logic [NB*W-1:0] WAKE_MASK = DEF_WAKE_MASK
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NB*W-1:0] pad_in,
    input  logic [NB*W-1:0] pin_dir,
    input  logic [NB*W-1:0] rise_en,
    input  logic [NB*W-1:0] fall_en,
    input  logic [NB-1:0]   clr_we,
    input  logic [W-1:0]    clr_data,
    input  logic            halted,
    output logic [NB*W-1:0] status_o,
    output logic            irq_pin0,
    output logic            irq_pin1,
    output logic            irq_shared,
    output logic            wake_req
);
    localparam int unsigned TOT = NB * W;

    logic [TOT-1:0] lvl_sync;
    logic [NB-1:0]  wake_hit;

    gpio_sync2 #(.W(TOT)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pad_in),
        .q_sync  (lvl_sync)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        gpio_edge_bank #(
            .W         (W),
            .WAKE_MASK (WAKE_MASK[b*W +: W])
        ) i_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .lvl_i      (lvl_sync[b*W +: W]),
            .dir_i      (pin_dir[b*W +: W]),
            .rise_en_i  (rise_en[b*W +: W]),
            .fall_en_i  (fall_en[b*W +: W]),
            .clr_we_i   (clr_we[b]),
            .clr_data_i (clr_data),
            .halted_i   (halted),
            .status_o   (status_o[b*W +: W]),
            .wake_hit_o (wake_hit[b])
        );
    end

    gpio_irq_agg #(.NB(NB), .W(W)) i_agg (
        .clk        (clk),
        .rst_n      (rst_n),
        .status_i   (status_o),
        .wake_hit_i (wake_hit),
        .irq0_o     (irq_pin0),
        .irq1_o     (irq_pin1),
        .irqx_o     (irq_shared),
        .wake_o     (wake_req)
    );

    // R9: outputs quiet right after reset release
    p_reset_quiet_r9: assert property (@(posedge clk)
        $rose(rst_n) |-> (status_o == '0 && !irq_pin0 && !irq_pin1 && !irq_shared && !wake_req));
endmodule

// File: tb/test_gpio_edge_irq_top.sv
`timescale 1ns/1ps
module test_gpio_edge_irq_top;
    localparam int NB = 4;
    localparam int W  = 32;
    localparam int T  = NB * W;
    localparam logic [T-1:0] MASK = 128'h0012007F_EC080000_002001FC_8003FE1B;

    typedef struct packed {
        logic [6:0] pin;
        logic       lvl;
        logic       rise;
        logic       fall;
        logic       dir;
        logic       halt;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{7'd0,   1'b1, 1'b1, 1'b0, 1'b0, 1'b0},  // R1 rise on pin 0
        '{7'd0,   1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R2 fall not enabled
        '{7'd1,   1'b1, 1'b0, 1'b1, 1'b0, 1'b0},  // R1 rise not enabled
        '{7'd1,   1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R2 fall on pin 1
        '{7'd2,   1'b1, 1'b1, 1'b0, 1'b1, 1'b1},  // R3 output pin
        '{7'd40,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1},  // R8 wake bank 1
        '{7'd2,   1'b0, 1'b0, 1'b1, 1'b0, 1'b1},  // R8 unmasked pin
        '{7'd127, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},  // R7 top pin
        '{7'd96,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1},  // R8 wake w/o enable
        '{7'd0,   1'b0, 1'b1, 1'b1, 1'b0, 1'b1}   // no change
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [T-1:0] pad_in = '0, pin_dir = '0, rise_en = '0, fall_en = '0;
    logic [NB-1:0] clr_we = '0;
    logic [W-1:0] clr_data = '0;
    logic         halted = 1'b0;
    logic [T-1:0] status_o;
    logic         irq_pin0, irq_pin1, irq_shared, wake_req;

    int n_tests = 0, n_fail = 0, wake_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    always @(posedge clk) if (wake_req) wake_cnt <= wake_cnt + 1;

    gpio_edge_irq_top i_gpio_edge_irq_top (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pin_dir(pin_dir),
        .rise_en(rise_en), .fall_en(fall_en), .clr_we(clr_we),
        .clr_data(clr_data), .halted(halted), .status_o(status_o),
        .irq_pin0(irq_pin0), .irq_pin1(irq_pin1), .irq_shared(irq_shared),
        .wake_req(wake_req)
    );

    task automatic check(input string req, input logic [T-1:0] act, input logic [T-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_all();
        clr_we = '1; clr_data = '1;
        neg(1);
        clr_we = '0; clr_data = '0;
        neg(2);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        neg(3);
        check("R9 status in reset", status_o, '0);
        check("R9 irqs in reset", {irq_pin0, irq_pin1, irq_shared, wake_req}, '0);
        rst_n = 1'b1;
        neg(3);
        check("R9 status after reset", status_o, '0);
        check("R9 irqs after reset", {irq_pin0, irq_pin1, irq_shared, wake_req}, '0);

        for (int v = 0; v < NV; v++) begin
            automatic vec_t  x = VECS[v];
            automatic logic  old = pad_in[x.pin];
            automatic logic  setb, wk;
            automatic logic [T-1:0] exp_st;
            setb = ((x.rise && x.lvl && !old) || (x.fall && !x.lvl && old)) && !x.dir;
            wk   = (x.lvl != old) && !x.dir && x.halt && MASK[x.pin];
            exp_st = '0;
            exp_st[x.pin] = setb;
            rise_en = '0; fall_en = '0; pin_dir = '0;
            rise_en[x.pin] = x.rise; fall_en[x.pin] = x.fall; pin_dir[x.pin] = x.dir;
            halted = x.halt;
            neg(1);
            wake_cnt = 0;
            pad_in[x.pin] = x.lvl;
            neg(5);
            check($sformatf("R1/R2/R3 vec %0d status", v), status_o, exp_st);
            check($sformatf("R6/R7 vec %0d irqs", v), {irq_pin0, irq_pin1, irq_shared},
                  {setb && x.pin == 0, setb && x.pin == 1, setb && x.pin >= 2});
            check($sformatf("R8 vec %0d wake pulses", v), wake_cnt, wk ? 1 : 0);
            halted = 1'b0;
            clear_all();
        end

        // R6 latency: pin 0 rise
        rise_en = '0; fall_en = '0; pin_dir = '0; pad_in = '0;
        neg(4); clear_all();
        rise_en[0] = 1'b1; rise_en[3] = 1'b1; rise_en[4] = 1'b1;
        pad_in[0] = 1'b1;
        neg(2);
        check("R6 status not yet at E1", status_o[0], 1'b0);
        neg(1);
        check("R6 status after E2", status_o[0], 1'b1);
        check("R6 irq_pin0 not yet after E2", irq_pin0, 1'b0);
        neg(1);
        check("R6 irq_pin0 after E3", irq_pin0, 1'b1);

        // R4: sticky and partial clear
        pad_in[3] = 1'b1; pad_in[4] = 1'b1;
        neg(10);
        check("R4 sticky bits", status_o[4:0], 5'b11001);
        clr_we = 4'b0001; clr_data = 32'h0000_0008;
        neg(1);
        clr_we = '0; clr_data = '0;
        neg(1);
        check("R4 partial clear", status_o[4:0], 5'b10001);
        clr_we = 4'b0010; clr_data = '1;  // other bank: no effect on bank 0
        neg(1);
        clr_we = '0; clr_data = '0;
        neg(1);
        check("R4 other bank clear", status_o[4:0], 5'b10001);
        check("R7 shared high from bit 4", irq_shared, 1'b1);
        clear_all();
        check("R7 shared low after clear", irq_shared, 1'b0);

        // R5: clear and edge on bit 5 in the same cycle
        rise_en[5] = 1'b1;
        pad_in[5] = 1'b1;
        neg(2);
        clr_we = 4'b0001; clr_data = 32'h0000_0020;
        neg(1);
        clr_we = '0; clr_data = '0;
        check("R5 edge beats clear", status_o[5], 1'b1);
        clr_we = 4'b0001; clr_data = 32'h0000_0020;
        neg(1);
        clr_we = '0; clr_data = '0;
        check("R5 later clear works", status_o[5], 1'b0);

        // R8 single-cycle pulse on falling change of pin 0
        halted = 1'b1;
        pad_in[0] = 1'b0;
        neg(3);
        check("R8 wake high", wake_req, 1'b1);
        neg(1);
        check("R8 wake one cycle", wake_req, 1'b0);
        halted = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule